// File: doc/BRIEF.md
# Repeat-Accumulate Conversion Sequencer

This block sequences an external successive-approximation converter. It divides its input clock into a conversion-rate tick and issues a one-cycle request to the converter on a tick. It collects the converter's 12-bit samples and adds them into one 16-bit result. A configuration field selects how many samples form one result: 1, 4, 8 or 16. When the last sample of the group arrives, the block publishes the result. It then raises an end-of-conversion pulse, which is also latched in a sticky flag, and a window-compare request.

The block has two start disciplines. In the default mode, every conversion of a group waits for its own start request. In burst mode, one start runs the whole group without further starts. In burst mode the divider does not advance on every system clock. It advances only on strobes from a fixed-rate fast clock enable. A justify select places a single sample at the top of the result. The select has no effect when more than one sample is summed.

Top module: `adc_accum_seq`

## Requirements
- R1: With burst off, `sar_tick` is high for one cycle in every `cfg_div`+1 system clock cycles.
- R2: With burst on, the divider advances only in cycles where `fast_en` is high, so `sar_tick` repeats every `cfg_div`+1 `fast_en` strobes.
- R3: `cfg_rpt` sets the samples per result: 2'b00 gives 1, 2'b01 gives 4, 2'b10 gives 8, 2'b11 gives 16. A group issues exactly that many `conv_req` pulses.
- R4: `result` becomes the zero-extended sum of all samples of the group, with the sum started fresh for each group. It changes only in the cycle of the end-of-conversion pulse.
- R5: With burst off, after one conversion of a multi-sample group, no further `conv_req` is issued until `start` is asserted again.
- R6: With burst on, a single `start` runs every conversion of the group.
- R7: `eoc_pulse` and `win_req` are high together for exactly one cycle, one cycle after the final sample's `adc_done`.
- R8: `eoc_flag` is set by the end-of-conversion pulse and stays set until `eoc_clr`. When both happen in the same cycle, the set wins.
- R9: With `cfg_rpt` = 2'b00 and `cfg_ljust` = 1, `result` = sample << 4. In every other case the result is right-justified and `cfg_ljust` is ignored.
- R10: `busy` is high while a conversion is awaited or in flight. A `start` seen while `busy` is high has no effect.
- R11: After reset, `busy`, `conv_req`, `eoc_pulse`, `win_req`, `eoc_flag` are 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_div | input | 5 | Divider value; the tick period is value+1 source cycles |
| cfg_rpt | input | 2 | Samples-per-result select |
| cfg_burst | input | 1 | Burst mode enable |
| cfg_ljust | input | 1 | Left-justify select for single samples |
| fast_en | input | 1 | Fast-clock strobe that paces the divider in burst mode |
| start | input | 1 | Conversion start request |
| adc_data | input | 12 | Converter sample |
| adc_done | input | 1 | Converter sample valid |
| eoc_clr | input | 1 | Clears the sticky end-of-conversion flag |
| sar_tick | output | 1 | Converter clock tick |
| conv_req | output | 1 | One-cycle request to the converter |
| busy | output | 1 | Conversion awaited or in flight |
| result | output | 16 | Accumulated result |
| eoc_pulse | output | 1 | End-of-group pulse |
| eoc_flag | output | 1 | Sticky end-of-group flag |
| win_req | output | 1 | Window-compare request pulse |

## Verification
The bound checker watches several properties on every cycle:
- the tick spacing in non-burst mode;
- requests occurring only on ticks and while busy;
- the per-group request count staying within the selected size;
- the result moving only with the end pulse;
- the pairing and one-cycle width of the two pulses;
- the stickiness of the flag.

The bench's scenarios show the behaviours that a property cannot express. These are the actual sums and justification, the burst-mode pacing by the fast strobe, and the stalls that need a fresh start in non-burst mode. The bench also checks that starts issued while busy leave both the count and the sum unchanged.

// File: rtl/adc_accum_seq.sv
module adc_accum_seq #(
  parameter int DIV_W  = 5,
  parameter int DATA_W = 12,
  parameter int RES_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [1:0]        cfg_rpt,
  input  logic              cfg_burst,
  input  logic              cfg_ljust,
  input  logic              fast_en,
  input  logic              start,
  input  logic [DATA_W-1:0] adc_data,
  input  logic              adc_done,
  input  logic              eoc_clr,
  output logic              sar_tick,
  output logic              conv_req,
  output logic              busy,
  output logic [RES_W-1:0]  result,
  output logic              eoc_pulse,
  output logic              eoc_flag,
  output logic              win_req
);
  localparam int PAD_W = RES_W - DATA_W;

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_REQ, S_CONV} st_t;

  st_t              state;
  logic [DIV_W-1:0] div_cnt;
  logic [3:0]       cnt, last_idx;
  logic [RES_W-1:0] acc, acc_nxt, sample_r, sample_l;
  logic             src_en, last;

  assign src_en   = cfg_burst ? fast_en : 1'b1;
  assign sar_tick = src_en && (div_cnt >= cfg_div);
  assign busy     = (state == S_REQ) || (state == S_CONV);
  assign sample_r = {{PAD_W{1'b0}}, adc_data};
  assign sample_l = {adc_data, {PAD_W{1'b0}}};
  assign acc_nxt  = acc + sample_r;
  assign last     = (cnt == last_idx);

  always_comb begin
    case (cfg_rpt)
      2'b00:   last_idx = 4'd0;
      2'b01:   last_idx = 4'd3;
      2'b10:   last_idx = 4'd7;
      default: last_idx = 4'd15;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          div_cnt <= '0;
    else if (sar_tick)   div_cnt <= '0;
    else if (src_en)     div_cnt <= div_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      acc       <= '0;
      result    <= '0;
      conv_req  <= 1'b0;
      eoc_pulse <= 1'b0;
      win_req   <= 1'b0;
      eoc_flag  <= 1'b0;
    end else begin
      conv_req  <= 1'b0;
      eoc_pulse <= 1'b0;
      win_req   <= 1'b0;
      if (eoc_clr) eoc_flag <= 1'b0;
      case (state)
        S_IDLE, S_ARM: begin
          if (start) begin
            state <= S_REQ;
            if (state == S_IDLE) begin
              acc <= '0;
              cnt <= '0;
            end
          end
        end
        S_REQ: begin
          if (sar_tick) begin
            conv_req <= 1'b1;
            state    <= S_CONV;
          end
        end
        default: begin
          if (adc_done) begin
            if (last) begin
              result    <= (cfg_ljust && cfg_rpt == 2'b00) ? sample_l : acc_nxt;
              eoc_pulse <= 1'b1;
              win_req   <= 1'b1;
              eoc_flag  <= 1'b1;
              state     <= S_IDLE;
            end else begin
              acc   <= acc_nxt;
              cnt   <= cnt + 1'b1;
              state <= cfg_burst ? S_REQ : S_ARM;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_accum_seq_chk.sv
module adc_accum_seq_chk #(
  parameter int DIV_W = 5,
  parameter int RES_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] cfg_div,
  input logic [1:0]       cfg_rpt,
  input logic             cfg_burst,
  input logic             sar_tick,
  input logic             conv_req,
  input logic             busy,
  input logic [RES_W-1:0] result,
  input logic             eoc_pulse,
  input logic             eoc_flag,
  input logic             eoc_clr,
  input logic             win_req
);
  logic [DIV_W+1:0] gap;
  logic [DIV_W-1:0] prev_div;
  logic             seen, steady;
  logic [4:0]       req_cnt, grp_n;

  always_comb begin
    case (cfg_rpt)
      2'b00:   grp_n = 5'd1;
      2'b01:   grp_n = 5'd4;
      2'b10:   grp_n = 5'd8;
      default: grp_n = 5'd16;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap <= '0; seen <= 1'b0; steady <= 1'b0; prev_div <= '0; req_cnt <= '0;
    end else begin
      prev_div <= cfg_div;
      if (sar_tick) begin
        gap <= 1; seen <= 1'b1; steady <= !cfg_burst;
      end else begin
        if (gap != '1) gap <= gap + 1'b1;
        if (cfg_burst || cfg_div != prev_div) steady <= 1'b0;
      end
      if (eoc_pulse) req_cnt <= '0;
      else if (conv_req) req_cnt <= req_cnt + 1'b1;
    end
  end

  p_tick_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sar_tick && seen && steady && !cfg_burst && cfg_div == prev_div) |-> (gap == cfg_div + 1'b1));
  p_req_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> $past(sar_tick));
  p_group_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_cnt <= grp_n);
  p_result_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> eoc_pulse);
  p_eoc_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_pulse |=> !eoc_pulse);
  p_win_with_eoc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_pulse |-> win_req);
  p_eoc_with_win_r7: assert property (@(posedge clk) disable iff (!rst_n)
    win_req |-> eoc_pulse);
  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_pulse |-> eoc_flag);
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc_flag && !eoc_clr) |=> eoc_flag);
  p_req_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> busy);
endmodule

bind adc_accum_seq adc_accum_seq_chk #(.DIV_W(DIV_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_rpt(cfg_rpt),
  .cfg_burst(cfg_burst), .sar_tick(sar_tick), .conv_req(conv_req),
  .busy(busy), .result(result), .eoc_pulse(eoc_pulse), .eoc_flag(eoc_flag),
  .eoc_clr(eoc_clr), .win_req(win_req));

// File: tb/adc_accum_seq_test.sv
`timescale 1ns/1ps
module adc_accum_seq_test;
  logic clk = 0, rst_n = 0;
  logic [4:0] cfg_div = 0;
  logic [1:0] cfg_rpt = 0;
  logic cfg_burst = 0, cfg_ljust = 0, fast_en = 0, start = 0, adc_done = 0, eoc_clr = 0;
  logic [11:0] adc_data = 0;
  logic sar_tick, conv_req, busy, eoc_pulse, eoc_flag, win_req;
  logic [15:0] result;

  int checks = 0, errors = 0;
  int req_total = 0, eoc_total = 0, win_total = 0, done_total = 0, snap = 0;
  logic [11:0] vbase = 0, vstep = 0;

  always #4 clk = ~clk;

  adc_accum_seq uut (.clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_rpt(cfg_rpt),
    .cfg_burst(cfg_burst), .cfg_ljust(cfg_ljust), .fast_en(fast_en), .start(start),
    .adc_data(adc_data), .adc_done(adc_done), .eoc_clr(eoc_clr), .sar_tick(sar_tick),
    .conv_req(conv_req), .busy(busy), .result(result), .eoc_pulse(eoc_pulse),
    .eoc_flag(eoc_flag), .win_req(win_req));

  // {rpt, div, burst, ljust, base, step, expected}
  localparam logic [48:0] VEC [7] = '{
    {2'd0, 5'd0, 1'b0, 1'b0, 12'h123, 12'h000, 16'h0123},
    {2'd0, 5'd2, 1'b0, 1'b1, 12'hABC, 12'h000, 16'hABC0},
    {2'd1, 5'd1, 1'b0, 1'b0, 12'd100, 12'd10,  16'h01CC},
    {2'd2, 5'd3, 1'b1, 1'b0, 12'h200, 12'd1,   16'h101C},
    {2'd3, 5'd0, 1'b1, 1'b1, 12'hFFF, 12'h000, 16'hFFF0},
    {2'd3, 5'd4, 1'b0, 1'b0, 12'd0,   12'd5,   16'h0258},
    {2'd1, 5'd0, 1'b1, 1'b1, 12'h800, 12'h010, 16'h2060}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) fast_en <= ~fast_en;

  always @(negedge clk) begin
    if (conv_req) req_total++;
    if (eoc_pulse) eoc_total++;
    if (win_req) win_total++;
  end

  initial begin
    forever begin
      @(negedge clk);
      if (conv_req) begin
        repeat (3) @(negedge clk);
        adc_data = vbase + 12'(done_total - snap) * vstep;
        adc_done = 1;
        @(negedge clk);
        adc_done = 0;
        done_total++;
      end
    end
  end

  task automatic pulse_start();
    start = 1; @(negedge clk); start = 0;
  endtask

  task automatic clear_flag();
    eoc_clr = 1; @(negedge clk); eoc_clr = 0; @(negedge clk);
  endtask

  task automatic run_vec(input logic [48:0] v);
    int n, r0, e0, w0;
    cfg_rpt = v[48:47]; cfg_div = v[46:42]; cfg_burst = v[41]; cfg_ljust = v[40];
    vbase = v[39:28]; vstep = v[27:16];
    n = (cfg_rpt == 0) ? 1 : (2 << cfg_rpt);
    snap = done_total; r0 = req_total; e0 = eoc_total; w0 = win_total;
    @(negedge clk);
    if (cfg_burst) begin
      pulse_start();
      while (eoc_total == e0) @(negedge clk);
    end else begin
      for (int k = 0; k < n; k++) begin
        while (busy) @(negedge clk);
        pulse_start();
        while (done_total != snap + k + 1) @(negedge clk);
        if (k == 0 && n > 1) begin
          repeat (20) @(negedge clk);
          check(req_total - r0 == 1 && eoc_total == e0, "R5 stalls without start", req_total - r0, 1);
        end
      end
      while (eoc_total == e0) @(negedge clk);
    end
    @(negedge clk);
    check(result == v[15:0], "R4/R9 result", result, v[15:0]);
    check(req_total - r0 == n, cfg_burst ? "R3/R6 request count" : "R3 request count", req_total - r0, n);
    check(eoc_total - e0 == 1 && win_total - w0 == 1, "R7 pulses", eoc_total - e0, 1);
    check(eoc_flag == 1, "R8 flag set", eoc_flag, 1);
    clear_flag();
  endtask

  task automatic tick_gap(input int exp, input string tag);
    int g = 0;
    while (!sar_tick) @(negedge clk);
    @(negedge clk); g = 1;
    while (!sar_tick) begin @(negedge clk); g++; end
    check(g == exp, tag, g, exp);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int r0, e0;
    repeat (3) @(negedge clk);
    check(busy == 0 && conv_req == 0 && eoc_pulse == 0 && win_req == 0, "R11 reset controls", busy, 0);
    check(result == 0 && eoc_flag == 0, "R11 reset result/flag", result, 0);
    rst_n = 1;
    @(negedge clk);

    foreach (VEC[i]) run_vec(VEC[i]);

    cfg_burst = 0; cfg_div = 4; repeat (2) @(negedge clk);
    tick_gap(5, "R1 tick period");
    cfg_burst = 1; cfg_div = 2; repeat (2) @(negedge clk);
    tick_gap(6, "R2 burst tick on fast strobe");

    // R10: starts during busy ignored
    cfg_rpt = 1; cfg_div = 0; cfg_burst = 1; cfg_ljust = 0; vbase = 12'h010; vstep = 1;
    snap = done_total; r0 = req_total; e0 = eoc_total;
    pulse_start();
    while (eoc_total == e0) begin start = busy; @(negedge clk); end
    start = 0;
    @(negedge clk);
    check(result == 16'h0046, "R10 sum with busy starts", result, 16'h0046);
    repeat (30) @(negedge clk);
    check(req_total - r0 == 4, "R10 no extra conversions", req_total - r0, 4);

    // R8: sticky until clear
    check(eoc_flag == 1, "R8 flag sticky", eoc_flag, 1);
    clear_flag();
    check(eoc_flag == 0, "R8 flag cleared", eoc_flag, 0);
    check(result == 16'h0046, "R4 result held", result, 16'h0046);

    finish_run();
  end
endmodule